// File: doc/BRIEF.md
# Bus-to-Slow-Clock Configuration Bridge

This block is a peripheral slave on an APB bus of the kind with no wait-state signal. Every transfer takes exactly one setup cycle and one access cycle, and the slave can never hold the bus. The block keeps a configuration word and a status word in the bus clock domain. It hands each accepted configuration word to logic that runs on a slower clock, asynchronous to the bus clock. The bus clock is typically four to five times faster.

An accepted write loads a bus-domain holding register and sets a busy flag. It also flips a request level, which crosses a two-flop synchronizer into the slow domain. When the slow side sees the synchronized level change, it copies the holding register into its own output register and pulses a strobe for one slow cycle. It then returns an acknowledge level through a second synchronizer. When the bus side detects that acknowledge, busy clears.

Software polls the busy bit before writing a new configuration. A configuration write that arrives while busy is set is dropped, and a sticky overrun flag records the drop. Software clears that flag by writing a 1 to it.

Top module: `cfgx_bridge`

## Requirements
- R1: After bus-domain reset, reads of offset 0x0 and offset 0x4 return zero. After slow-domain reset, `slow_cfg` is zero and `slow_stb` is low.
- R2: A write to offset 0x0 while busy is clear stores `pwdata` in the holding register, which reads back at offset 0x0. It also sets busy (status offset 0x4, bit 0), and busy is already visible on the next transfer.
- R3: While busy is set, the holding register does not change.
- R4: Each accepted configuration write makes `slow_cfg` take the written value, with exactly one single-cycle `slow_stb` pulse in the slow clock domain.
- R5: Busy clears without further bus activity. When a read shows busy clear, `slow_cfg` already holds the last accepted value.
- R6: A write to offset 0x0 while busy is set is discarded: the holding register, `slow_cfg` and the strobe count are unaffected. It sets overrun (status bit 1).
- R7: Overrun stays set until a write to offset 0x4 with bit 1 set. A status write with bit 1 clear leaves overrun as it was. Status writes never change busy or the configuration.
- R8: Reads of any offset other than 0x0 and 0x4 return zero. Writes to such offsets change nothing.
- R9: Reads have no side effects. A read of offset 0x0 never starts a crossing or sets busy.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pclk | input | 1 | Bus clock |
| presetn | input | 1 | Bus-domain synchronous reset, active low |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access-phase indicator |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | ADDR_W | Byte offset within the block |
| pwdata | input | DATA_W | Write data |
| prdata | output | DATA_W | Read data, valid during a read access |
| sclk | input | 1 | Slow processing clock |
| srstn | input | 1 | Slow-domain synchronous reset, active low |
| slow_cfg | output | DATA_W | Configuration copy in the slow domain |
| slow_stb | output | 1 | One-cycle pulse in `sclk` when `slow_cfg` is updated |

## Verification
The bench issues a second configuration write straight after a first one, while the crossing is still in flight. A design that let that write through would corrupt the holding register in the middle of the crossing. The slow side could then latch the wrong value or a mix of both, and the strobe count would exceed the number of accepted writes. The bench also polls busy and compares `slow_cfg` at the moment busy reads clear, which catches a design that releases busy before the slow capture. It exercises status writes with bit 1 clear, reads of offset 0x0 and accesses to unmapped offsets. A design that cleared overrun on any write, or that started a crossing on a read or a stray address, would show a changed flag or an extra strobe.

// File: rtl/cfgx_pkg.sv
// Package: shared offsets and status bit positions for the configuration bridge.
// Assumes byte offsets; only the low address bits are decoded by the block.
package cfgx_pkg;
    localparam int OFS_CFG  = 0;  // configuration word, read/write
    localparam int OFS_STAT = 4;  // status word
    localparam int ST_BUSY  = 0;  // status bit: crossing in flight
    localparam int ST_OVR   = 1;  // status bit: sticky overrun, write 1 to clear
endpackage

// File: rtl/cfgx_sync.sv
// Module: multi-flop level synchronizer for a single-bit level signal.
// Assumes the input is a slowly changing level (a toggle), never a pulse.
module cfgx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rstn,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    // Shift the asynchronous level through the flop chain.
    always_ff @(posedge clk) begin
        if (!rstn) chain <= '0;
        else       chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/cfgx_bus_regs.sv
// Module: bus-domain register file of the bridge.
// Decodes APB transfers, holds the configuration word, and owns the busy and overrun
// flags and the request toggle. Assumes ack_sync is already synchronized to pclk.
module cfgx_bus_regs
    import cfgx_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 16
) (
    input  logic              pclk,
    input  logic              presetn,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [DATA_W-1:0] pwdata,
    input  logic              ack_sync,
    output logic [DATA_W-1:0] prdata,
    output logic [DATA_W-1:0] hold,
    output logic              busy,
    output logic              ovr,
    output logic              req_tgl
);
    localparam logic [ADDR_W-1:0] A_CFG  = ADDR_W'(OFS_CFG);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_STAT);

    logic hit_cfg, hit_stat, wr_acc, ack_seen, ack_evt;

    assign hit_cfg  = (paddr == A_CFG);
    assign hit_stat = (paddr == A_STAT);
    assign wr_acc   = psel && penable && pwrite;
    assign ack_evt  = (ack_sync != ack_seen);

    // Load the holding register and flip the request on an accepted config write.
    always_ff @(posedge pclk) begin
        if (!presetn) begin
            hold    <= '0;
            req_tgl <= 1'b0;
        end else if (wr_acc && hit_cfg && !busy) begin
            hold    <= pwdata;
            req_tgl <= ~req_tgl;
        end
    end

    // Busy: set by an accepted config write, cleared by the returned acknowledge.
    always_ff @(posedge pclk) begin
        if (!presetn) begin
            busy     <= 1'b0;
            ack_seen <= 1'b0;
        end else begin
            ack_seen <= ack_sync;
            if (wr_acc && hit_cfg && !busy) busy <= 1'b1;
            else if (ack_evt)               busy <= 1'b0;
        end
    end

    // Overrun: set by a dropped config write, cleared by writing 1 to its status bit.
    always_ff @(posedge pclk) begin
        if (!presetn)                            ovr <= 1'b0;
        else if (wr_acc && hit_cfg && busy)      ovr <= 1'b1;
        else if (wr_acc && hit_stat && pwdata[ST_OVR]) ovr <= 1'b0;
    end

    // Read mux: configuration, status, or zero for unmapped offsets.
    always_comb begin
        prdata = '0;
        if (psel && !pwrite) begin
            if (hit_cfg) begin
                prdata = hold;
            end else if (hit_stat) begin
                prdata[ST_BUSY] = busy;
                prdata[ST_OVR]  = ovr;
            end
        end
    end
endmodule

// File: rtl/cfgx_slow_capture.sv
// Module: slow-domain capture of the configuration word.
// Assumes hold_data is stable whenever req_sync differs from the last seen level.
module cfgx_slow_capture #(
    parameter int DATA_W = 16
) (
    input  logic              sclk,
    input  logic              srstn,
    input  logic              req_sync,
    input  logic [DATA_W-1:0] hold_data,
    output logic [DATA_W-1:0] cfg_q,
    output logic              stb,
    output logic              ack_tgl
);
    logic req_seen;

    // Capture the held word and pulse the strobe when the request level changes.
    always_ff @(posedge sclk) begin
        if (!srstn) begin
            req_seen <= 1'b0;
            cfg_q    <= '0;
            stb      <= 1'b0;
        end else if (req_sync != req_seen) begin
            req_seen <= req_sync;
            cfg_q    <= hold_data;
            stb      <= 1'b1;
        end else begin
            stb      <= 1'b0;
        end
    end

    assign ack_tgl = req_seen;
endmodule

// File: rtl/cfgx_bridge.sv
// Module: top of the configuration bridge from the APB clock to a slow clock.
// Assumes pclk and sclk are asynchronous and each domain has its own synchronous reset.
module cfgx_bridge #(
    parameter int ADDR_W   = 4,
    parameter int DATA_W   = 16,
    parameter int SYNC_STG = 2
) (
    input  logic              pclk,
    input  logic              presetn,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [DATA_W-1:0] pwdata,
    output logic [DATA_W-1:0] prdata,
    input  logic              sclk,
    input  logic              srstn,
    output logic [DATA_W-1:0] slow_cfg,
    output logic              slow_stb
);
    logic [DATA_W-1:0] bus_hold;
    logic bus_busy, bus_ovr, bus_req_tgl, req_s, ack_tgl, ack_p;

    cfgx_bus_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
        .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable),
        .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .ack_sync(ack_p),
        .prdata(prdata), .hold(bus_hold), .busy(bus_busy), .ovr(bus_ovr),
        .req_tgl(bus_req_tgl)
    );

    cfgx_sync #(.STAGES(SYNC_STG)) u_req_sync (
        .clk(sclk), .rstn(srstn), .d(bus_req_tgl), .q(req_s)
    );

    cfgx_slow_capture #(.DATA_W(DATA_W)) u_cap (
        .sclk(sclk), .srstn(srstn), .req_sync(req_s), .hold_data(bus_hold),
        .cfg_q(slow_cfg), .stb(slow_stb), .ack_tgl(ack_tgl)
    );

    cfgx_sync #(.STAGES(SYNC_STG)) u_ack_sync (
        .clk(pclk), .rstn(presetn), .d(ack_tgl), .q(ack_p)
    );
endmodule

// File: rtl/cfgx_bridge_chk.sv
// Module: assertion checker for the configuration bridge, attached by bind.
// Assumes it observes the bus-domain flags and the holding register of the top.
module cfgx_bridge_chk #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 16
) (
    input logic              pclk,
    input logic              presetn,
    input logic              sclk,
    input logic              srstn,
    input logic              psel,
    input logic              penable,
    input logic              pwrite,
    input logic [ADDR_W-1:0] paddr,
    input logic [DATA_W-1:0] prdata,
    input logic [DATA_W-1:0] hold,
    input logic              busy,
    input logic              ovr,
    input logic              req_tgl,
    input logic              slow_stb
);
    logic cfg_wr, unm_rd;
    assign cfg_wr = psel && penable && pwrite && (paddr == ADDR_W'(0));
    assign unm_rd = psel && !pwrite && (paddr != ADDR_W'(0)) && (paddr != ADDR_W'(4));

    // R2: accepted config write leaves busy set on the next cycle
    p_busy_set_r2: assert property (@(posedge pclk) disable iff (!presetn)
        (cfg_wr && !busy) |=> busy);

    // R3: holding register frozen while a crossing is pending
    p_hold_stable_r3: assert property (@(posedge pclk) disable iff (!presetn)
        (busy && $past(busy) && $past(presetn)) |-> $stable(hold));

    // R6: a config write while busy sets overrun and leaves the request level alone
    p_drop_busy_r6: assert property (@(posedge pclk) disable iff (!presetn)
        (cfg_wr && busy) |=> (ovr && $stable(req_tgl) && $stable(hold)));

    // R9: no request toggle without an accepted config write
    p_req_only_on_write_r9: assert property (@(posedge pclk) disable iff (!presetn)
        !(cfg_wr && !busy) |=> $stable(req_tgl));

    // R4: strobe lasts a single slow cycle
    p_stb_single_r4: assert property (@(posedge sclk) disable iff (!srstn)
        slow_stb |=> !slow_stb);

    // R8: unmapped reads return zero
    p_unmapped_zero_r8: assert property (@(posedge pclk) disable iff (!presetn)
        unm_rd |-> (prdata == '0));
endmodule

bind cfgx_bridge cfgx_bridge_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .pclk(pclk), .presetn(presetn), .sclk(sclk), .srstn(srstn),
    .psel(psel), .penable(penable), .pwrite(pwrite), .paddr(paddr),
    .prdata(prdata), .hold(bus_hold), .busy(bus_busy), .ovr(bus_ovr),
    .req_tgl(bus_req_tgl), .slow_stb(slow_stb)
);

// File: tb/test_cfgx_bridge.sv
module test_cfgx_bridge;
    localparam int AW = 4;
    localparam int DW = 16;

    logic pclk = 1'b0, sclk = 1'b0, presetn = 1'b0, srstn = 1'b0;
    logic psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [AW-1:0] paddr = '0;
    logic [DW-1:0] pwdata = '0;
    logic [DW-1:0] prdata, slow_cfg;
    logic slow_stb;

    int n_cmp = 0, n_bad = 0, stb_cnt = 0, exp_stb = 0;
    logic [DW-1:0] exp_cfg = '0;
    logic exp_ovr = 1'b0;
    logic [DW-1:0] rd;
    logic done = 1'b0;

    always #5 pclk = ~pclk;   // 100 MHz bus clock
    always #22 sclk = ~sclk;  // about 4.4x slower processing clock

    cfgx_bridge #(.ADDR_W(AW), .DATA_W(DW)) i_cfgx_bridge (
        .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable),
        .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
        .sclk(sclk), .srstn(srstn), .slow_cfg(slow_cfg), .slow_stb(slow_stb)
    );

    always @(negedge sclk) if (srstn && slow_stb) stb_cnt++;

    function automatic logic [DW-1:0] stat_word(input logic b, input logic o);
        logic [DW-1:0] w = '0;
        w[0] = b;
        w[1] = o;
        return w;
    endfunction

    task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic apb_wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(posedge pclk); #1;
        psel = 1'b1; penable = 1'b0; pwrite = 1'b1; paddr = a; pwdata = d;
        @(posedge pclk); #1;
        penable = 1'b1;
        @(posedge pclk); #1;
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    endtask

    task automatic apb_rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
        @(posedge pclk); #1;
        psel = 1'b1; penable = 1'b0; pwrite = 1'b0; paddr = a;
        @(posedge pclk); #1;
        penable = 1'b1;
        #3 d = prdata;
        @(posedge pclk); #1;
        psel = 1'b0; penable = 1'b0;
    endtask

    // Poll status until busy clears; then slow_cfg must already hold the value (R5).
    task automatic wait_idle(input string tag);
        logic [DW-1:0] s;
        int k = 0;
        apb_rd(AW'(4), s);
        while (s[0] && k < 200) begin
            apb_rd(AW'(4), s);
            k++;
        end
        check({tag, " R5 busy clears"}, {15'd0, s[0]}, '0);
        check({tag, " R5 slow_cfg at idle"}, slow_cfg, exp_cfg);
        check({tag, " R6 overrun state"}, {15'd0, s[1]}, {15'd0, exp_ovr});
        repeat (12) @(posedge sclk);
        check({tag, " R4 strobe count"}, DW'(stb_cnt), DW'(exp_stb));
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            n_bad++; n_cmp++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [DW-1:0] v, v2;
        void'($urandom(32'h1234_5eed));
        repeat (6) @(posedge sclk);
        #1 presetn = 1'b1; srstn = 1'b1;

        // R1: reset state
        apb_rd(AW'(0), rd); check("R1 cfg after reset", rd, '0);
        apb_rd(AW'(4), rd); check("R1 status after reset", rd, '0);
        check("R1 slow_cfg after reset", slow_cfg, '0);
        check("R1 no strobe after reset", DW'(stb_cnt), '0);

        // R9: reading config starts no crossing
        apb_rd(AW'(0), rd);
        apb_rd(AW'(4), rd); check("R9 read leaves busy clear", rd, '0);

        // R2/R3/R6: write, then a second write while busy
        v = 16'hA5C3; v2 = 16'h1E0F;
        apb_wr(AW'(0), v); exp_cfg = v; exp_stb++;
        apb_rd(AW'(4), rd); check("R2 busy set after write", rd, stat_word(1'b1, 1'b0));
        apb_wr(AW'(0), v2); exp_ovr = 1'b1;
        apb_rd(AW'(0), rd); check("R3 hold unchanged while busy", rd, v);
        wait_idle("directed");

        // R7: status write with bit1 clear keeps overrun; bit1 set clears it
        apb_wr(AW'(4), 16'hFFFD);
        apb_rd(AW'(4), rd); check("R7 overrun kept", rd, stat_word(1'b0, 1'b1));
        apb_rd(AW'(0), rd); check("R7 config unaffected", rd, v);
        apb_wr(AW'(4), 16'h0002); exp_ovr = 1'b0;
        apb_rd(AW'(4), rd); check("R7 overrun cleared", rd, '0);

        // R8: unmapped accesses
        for (int a = 1; a < 16; a++) begin
            if (a == 4) continue;
            apb_wr(AW'(a), 16'hBEEF);
            apb_rd(AW'(a), rd); check("R8 unmapped read zero", rd, '0);
        end
        apb_rd(AW'(0), rd); check("R8 config unaffected", rd, v);
        apb_rd(AW'(4), rd); check("R8 status unaffected", rd, '0);
        check("R8 no strobe", DW'(stb_cnt), DW'(exp_stb));

        // R2..R7: random traffic
        for (int i = 0; i < 40; i++) begin
            v = DW'($urandom);
            apb_wr(AW'(0), v); exp_cfg = v; exp_stb++;
            apb_rd(AW'(0), rd); check("R2 readback", rd, v);
            if ($urandom_range(0, 2) == 0) begin
                apb_wr(AW'(0), ~v); exp_ovr = 1'b1;
                apb_rd(AW'(0), rd); check("R6 dropped write", rd, v);
            end
            wait_idle("random");
            if (exp_ovr && $urandom_range(0, 1) == 1) begin
                apb_wr(AW'(4), 16'h0002); exp_ovr = 1'b0;
                apb_rd(AW'(4), rd); check("R7 clear", rd, '0);
            end
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule